// File: doc/BRIEF.md
# Bridge Switch Short-Fault Locator

This block watches a four-switch bridge for a switch that has failed short and names the faulty switch. It takes the four gate commands, a one-bit overcurrent comparator output and a one-bit winding-polarity comparator output. From the two upper gate commands it works out which of four conduction modes the bridge is in. Only while both legs are driven in complementary fashion does it combine that mode with the overcurrent bit to form a mode-gated overcurrent term. The first such term to appear decides which pair of switches can be at fault.

In two of the modes the polarity bit separates the pair at once. In the other two modes the polarity bit cannot tell the candidates apart. The block then forces every gate off for a programmable hold, then drives a single probe switch for a programmable observation window, and samples the polarity bit once at a programmable settle point inside that window. The verdict is kept in active-low flags, one per switch, and stays put until a synchronous clear re-arms the block. The surrounding controller uses `gate_lock` and `gate_force` to override its own gate commands.

The controller is built around four states. WATCH waits for a term. HOLD keeps all gates forced off. PROBE drives the probe switch. DONE holds the verdict with all gates forced off. The transitions are:
- WATCH to DONE, on a term in mode (1,1) or (0,0).
- WATCH to HOLD, on a term in mode (1,0) or (0,1).
- HOLD to PROBE, when the hold count expires.
- PROBE to DONE, when the window count expires.
- Any state to WATCH, on clear.

Top module: `shortfault_locator`

## Requirements
- R1: The mode is the pair {gate_cmd[0], gate_cmd[2]}, written as (s1,s3). A mode term can only fire when gate_cmd[1] is the inverse of gate_cmd[0] and gate_cmd[3] is the inverse of gate_cmd[2]. Dead-time patterns (both switches of a leg off) and overlap patterns (both on) never raise `fault_det`.
- R2: `sid_async` and `sm_async` each pass through a two-flop synchronizer. With a valid mode held, `fault_det` and `gate_lock` both rise on the third rising clock edge after `sid_async` goes high.
- R3: `fault_onehot` uses bit 0 for Q1, bit 1 for Q2, bit 2 for Q3 and bit 3 for Q4. A first term in mode (1,1) is resolved on the same edge that raises `fault_det`: synchronized sm low gives Q2 (4'b0010), and sm high gives Q4 (4'b1000).
- R4: A first term in mode (0,0) is resolved immediately in the same way: sm high gives Q1 (4'b0001), and sm low gives Q3 (4'b0100).
- R5: A first term in mode (1,0) or (0,1) forces `gate_force` to all zeros with `gate_lock` high for exactly HOLD_CYC cycles.
- R6: After the hold, `gate_force` drives a single probe switch for exactly WIN_CYC cycles: Q2 (4'b0010) for mode (1,0), and Q1 (4'b0001) for mode (0,1). It then returns to all zeros, with `gate_lock` still high.
- R7: The probe verdict uses synchronized sm sampled once, at probe cycle SETTLE_CYC+1. High names the driven switch. Low names the other candidate: Q3 for mode (1,0), Q4 for mode (0,1). Changes of sm after the sample do not alter the verdict.
- R8: Only the first term is honoured. Later overcurrent events, in any mode, leave `fault_onehot`, `fault_det`, `gate_lock` and `gate_force` unchanged.
- R9: A synchronous `clear` returns every output to zero and re-arms detection. It takes priority over a term present in the same cycle.
- R10: After reset, `fault_det`, `gate_lock`, `gate_force` and `fault_onehot` are all zero.
- R11: `fault_onehot` and `gate_force` never have more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear; re-arms detection |
| gate_cmd | input | 4 | Gate commands, bit k-1 drives switch Qk |
| sid_async | input | 1 | Overcurrent comparator output, unsynchronized |
| sm_async | input | 1 | Winding-polarity comparator output, unsynchronized |
| fault_det | output | 1 | Short-circuit fault detected |
| gate_lock | output | 1 | Request to replace the gate commands with gate_force |
| gate_force | output | 4 | Gate override pattern, bit k-1 drives Qk |
| fault_onehot | output | 4 | Faulty switch, bit k-1 marks Qk; zero while unresolved |

## Verification
The assertions assume certain input timing. gate_cmd must be steady across the edge where a synchronized overcurrent first meets a valid mode. The polarity input must be steady for at least two cycles before the settle sample, so the synchronizer delivers a single clean level. The stimulus respects this: it changes inputs only on falling edges, holds each gate pattern fixed before raising the overcurrent bit, sets the polarity level at the first probe cycle, and flips it only after the sample point, so that the ignore rule is exercised. Random trials draw the mode and polarity level from a fixed seed. Directed cases cover dead-time and overlap gate patterns, later events after a verdict, and a clear that coincides with a live overcurrent.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

    typedef enum logic [1:0] {
        ST_WATCH = 2'd0,
        ST_HOLD  = 2'd1,
        ST_PROBE = 2'd2,
        ST_DONE  = 2'd3
    } sfl_state_e;

    // switch codes, bit k-1 = Qk
    localparam logic [3:0] SW_Q1 = 4'b0001;
    localparam logic [3:0] SW_Q2 = 4'b0010;
    localparam logic [3:0] SW_Q3 = 4'b0100;
    localparam logic [3:0] SW_Q4 = 4'b1000;

    // mode = {s1, s3}
    localparam logic [1:0] MD_LO_LO = 2'b00;
    localparam logic [1:0] MD_LO_HI = 2'b01;
    localparam logic [1:0] MD_HI_LO = 2'b10;
    localparam logic [1:0] MD_HI_HI = 2'b11;

    function automatic logic sfl_needs_probe(input logic [1:0] md);
        return (md == MD_HI_LO) || (md == MD_LO_HI);
    endfunction

    // immediate polarity resolution for modes where sm separates the pair
    function automatic logic [3:0] sfl_direct_pick(input logic [1:0] md, input logic sm);
        logic [3:0] r;
        unique case (md)
            MD_HI_HI: r = sm ? SW_Q4 : SW_Q2;
            MD_LO_LO: r = sm ? SW_Q1 : SW_Q3;
            default:  r = 4'b0000;
        endcase
        return r;
    endfunction

    // single switch driven during the probe window
    function automatic logic [3:0] sfl_probe_gate(input logic [1:0] md);
        logic [3:0] r;
        unique case (md)
            MD_HI_LO: r = SW_Q2;
            MD_LO_HI: r = SW_Q1;
            default:  r = 4'b0000;
        endcase
        return r;
    endfunction

    // probe verdict: sm high -> driven switch, low -> other candidate
    function automatic logic [3:0] sfl_probe_pick(input logic [1:0] md, input logic sm);
        logic [3:0] other;
        unique case (md)
            MD_HI_LO: other = SW_Q3;
            MD_LO_HI: other = SW_Q4;
            default:  other = 4'b0000;
        endcase
        return sm ? sfl_probe_gate(md) : other;
    endfunction

endpackage

// File: rtl/sfl_sync.sv
module sfl_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], din[b]};
            end
        end
        assign dout[b] = chain[LAST];
    end
endmodule

// File: rtl/sfl_mode_gate.sv
module sfl_mode_gate (
    input  logic [3:0] gate_cmd,
    input  logic       sid_s,
    output logic [3:0] term,
    output logic       hit,
    output logic [1:0] hit_mode
);
    import sfl_pkg::*;

    localparam int NUM_MODES = 4;

    logic       legs_ok;
    logic [1:0] md;

    // dead time or overlap on either leg suppresses every term (R1)
    assign legs_ok = (gate_cmd[1] == ~gate_cmd[0]) && (gate_cmd[3] == ~gate_cmd[2]);
    assign md      = {gate_cmd[0], gate_cmd[2]};

    for (genvar m = 0; m < NUM_MODES; m++) begin : g_term
        assign term[m] = legs_ok && sid_s && (md == 2'(m));
    end

    always_comb begin
        hit_mode = MD_LO_LO;
        for (int i = 0; i < NUM_MODES; i++) begin
            if (term[i]) hit_mode = 2'(i);
        end
    end

    assign hit = |term;
endmodule

// File: rtl/sfl_resolver.sv
module sfl_resolver #(
    parameter int HOLD_CYC   = 5,
    parameter int WIN_CYC    = 6,
    parameter int SETTLE_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       hit,
    input  logic [1:0] hit_mode,
    input  logic       sm_s,
    output logic       fault_det,
    output logic       gate_lock,
    output logic [3:0] gate_force,
    output logic [3:0] fault_onehot
);
    import sfl_pkg::*;

    localparam int MAX_CYC = (HOLD_CYC > WIN_CYC) ? HOLD_CYC : WIN_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] WIN_LAST  = CNT_W'(WIN_CYC - 1);
    localparam logic [CNT_W-1:0] SMP_AT    = CNT_W'(SETTLE_CYC);

    sfl_state_e       st, st_nx;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       mode_q;
    logic             smp_q;
    logic [3:0]       flag_n;   // active-low per-switch fault flags

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_WATCH: if (hit) st_nx = sfl_needs_probe(hit_mode) ? ST_HOLD : ST_DONE;
            ST_HOLD:  if (cnt == HOLD_LAST) st_nx = ST_PROBE;
            ST_PROBE: if (cnt == WIN_LAST) st_nx = ST_DONE;
            ST_DONE:  st_nx = ST_DONE;
            default:  st_nx = ST_WATCH;
        endcase
        if (clear) st_nx = ST_WATCH;
    end

    // state and working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_WATCH;
            cnt    <= '0;
            mode_q <= MD_LO_LO;
            smp_q  <= 1'b0;
            flag_n <= '1;
        end else begin
            st <= st_nx;
            if (st_nx != st) begin
                cnt <= '0;
            end else if (cnt != '1) begin
                cnt <= cnt + 1'b1;
            end
            if (clear) begin
                flag_n <= '1;
                smp_q  <= 1'b0;
            end else begin
                unique case (st)
                    ST_WATCH: begin
                        if (hit) begin
                            mode_q <= hit_mode;
                            if (!sfl_needs_probe(hit_mode)) begin
                                flag_n <= ~sfl_direct_pick(hit_mode, sm_s);
                            end
                        end
                    end
                    ST_PROBE: begin
                        if (cnt == SMP_AT) smp_q <= sm_s;
                        if (cnt == WIN_LAST) flag_n <= ~sfl_probe_pick(mode_q, smp_q);
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        fault_det  = 1'b0;
        gate_lock  = 1'b0;
        gate_force = 4'b0000;
        unique case (st)
            ST_WATCH: ;
            ST_HOLD: begin
                fault_det = 1'b1;
                gate_lock = 1'b1;
            end
            ST_PROBE: begin
                fault_det  = 1'b1;
                gate_lock  = 1'b1;
                gate_force = sfl_probe_gate(mode_q);
            end
            ST_DONE: begin
                fault_det = 1'b1;
                gate_lock = 1'b1;
            end
            default: ;
        endcase
        fault_onehot = ~flag_n;
    end

    AST_VERDICT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fault_onehot)); // R11
    AST_FORCE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gate_force) <= 1); // R11
    AST_FORCE_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_force != 4'b0000) |-> gate_lock); // R6
    AST_PROBE_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_force != 4'b0000) |-> $past(gate_lock)); // R5
    AST_DET_FROM_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_det) |-> $past(hit)); // R2
    AST_DET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_det && !clear) |=> fault_det); // R8
    AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_onehot != 4'b0000) && !clear) |=> $stable(fault_onehot)); // R8
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!fault_det && fault_onehot == 4'b0000)); // R9
endmodule

// File: rtl/shortfault_locator.sv
module shortfault_locator #(
    parameter int HOLD_CYC   = 5,
    parameter int WIN_CYC    = 6,
    parameter int SETTLE_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic [3:0] gate_cmd,
    input  logic       sid_async,
    input  logic       sm_async,
    output logic       fault_det,
    output logic       gate_lock,
    output logic [3:0] gate_force,
    output logic [3:0] fault_onehot
);
    logic [1:0] sync_q;
    logic [3:0] term;
    logic       hit;
    logic [1:0] hit_mode;

    sfl_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sm_async, sid_async}),
        .dout (sync_q)
    );

    sfl_mode_gate u_mode (
        .gate_cmd(gate_cmd),
        .sid_s   (sync_q[0]),
        .term    (term),
        .hit     (hit),
        .hit_mode(hit_mode)
    );

    sfl_resolver #(
        .HOLD_CYC  (HOLD_CYC),
        .WIN_CYC   (WIN_CYC),
        .SETTLE_CYC(SETTLE_CYC)
    ) u_res (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .hit         (hit),
        .hit_mode    (hit_mode),
        .sm_s        (sync_q[1]),
        .fault_det   (fault_det),
        .gate_lock   (gate_lock),
        .gate_force  (gate_force),
        .fault_onehot(fault_onehot)
    );

    AST_TERM_EXCLUSIVE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (gate_cmd[1] != gate_cmd[0] && gate_cmd[3] != gate_cmd[2])); // R1
endmodule

// File: tb/shortfault_locator_test.sv
module shortfault_locator_test;
    localparam int HOLD_CYC   = 5;
    localparam int WIN_CYC    = 6;
    localparam int SETTLE_CYC = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear = 1'b0;
    logic [3:0] gate_cmd = 4'b0000;
    logic       sid_async = 1'b0;
    logic       sm_async = 1'b0;
    logic       fault_det, gate_lock;
    logic [3:0] gate_force, fault_onehot;

    int compared = 0;
    int mismatched = 0;

    always #4 clk = ~clk;

    shortfault_locator #(
        .HOLD_CYC(HOLD_CYC), .WIN_CYC(WIN_CYC), .SETTLE_CYC(SETTLE_CYC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .gate_cmd(gate_cmd),
        .sid_async(sid_async), .sm_async(sm_async), .fault_det(fault_det),
        .gate_lock(gate_lock), .gate_force(gate_force), .fault_onehot(fault_onehot)
    );

    function automatic logic [3:0] gates_for(input logic [1:0] md);
        return {~md[0], md[0], ~md[1], md[1]};
    endfunction

    function automatic logic probe_mode(input logic [1:0] md);
        return md == 2'b10 || md == 2'b01;
    endfunction

    function automatic logic [3:0] exp_fault(input logic [1:0] md, input logic sm);
        case (md)
            2'b11:   return sm ? 4'b1000 : 4'b0010;
            2'b00:   return sm ? 4'b0001 : 4'b0100;
            2'b10:   return sm ? 4'b0010 : 4'b0100;
            default: return sm ? 4'b0001 : 4'b1000;
        endcase
    endfunction

    function automatic logic [3:0] exp_probe(input logic [1:0] md);
        return (md == 2'b10) ? 4'b0010 : 4'b0001;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic drain_and_clear();
        sid_async = 1'b0;
        repeat (3) @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    // one full fault episode; ends on the negedge where the verdict is visible
    task automatic run_event(input logic [1:0] md, input logic sm_val);
        int hcnt;
        int pcnt;
        gate_cmd = gates_for(md);
        sm_async = probe_mode(md) ? ~sm_val : sm_val;
        repeat (3) @(negedge clk);
        sid_async = 1'b1;
        repeat (2) @(negedge clk);
        check(fault_det == 1'b0, "R2 det early", fault_det, 0);
        @(negedge clk);
        check(fault_det && gate_lock, "R2 det+lock on third edge", {fault_det, gate_lock}, 3);
        sid_async = 1'b0;
        if (!probe_mode(md)) begin
            check(fault_onehot == exp_fault(md, sm_val), "R3/R4 direct verdict",
                  fault_onehot, exp_fault(md, sm_val));
        end else begin
            hcnt = 1;
            check(gate_force == 4'b0000, "R5 hold forced off", gate_force, 0);
            for (int k = 0; k < 4 * HOLD_CYC; k++) begin
                @(negedge clk);
                if (gate_force != 4'b0000) break;
                hcnt++;
            end
            check(hcnt == HOLD_CYC, "R5 hold length", hcnt, HOLD_CYC);
            check(gate_force == exp_probe(md), "R6 probe pattern", gate_force, exp_probe(md));
            sm_async = sm_val;
            pcnt = 1;
            for (int k = 0; k < 4 * WIN_CYC; k++) begin
                @(negedge clk);
                if (gate_force == 4'b0000) break;
                pcnt++;
                if (pcnt == SETTLE_CYC + 1) sm_async = ~sm_val; // after sample: R7 ignore
            end
            check(pcnt == WIN_CYC, "R6 window length", pcnt, WIN_CYC);
            check(gate_lock == 1'b1, "R6 lock after window", gate_lock, 1);
            check(fault_onehot == exp_fault(md, sm_val), "R7 probe verdict",
                  fault_onehot, exp_fault(md, sm_val));
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin : main
        logic [3:0] held;
        void'($urandom(32'd7351));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check({fault_det, gate_lock, gate_force, fault_onehot} == 10'd0, "R10 reset outputs",
              {fault_det, gate_lock, gate_force, fault_onehot}, 0);

        // R1 dead time and overlap never trigger
        gate_cmd = 4'b0000;
        sid_async = 1'b1;
        repeat (6) @(negedge clk);
        check(fault_det == 1'b0, "R1 dead time ignored", fault_det, 0);
        gate_cmd = 4'b0111;
        repeat (4) @(negedge clk);
        check(fault_det == 1'b0, "R1 overlap ignored", fault_det, 0);
        gate_cmd = 4'b1101;
        repeat (4) @(negedge clk);
        check(fault_det == 1'b0, "R1 second leg overlap ignored", fault_det, 0);
        drain_and_clear();

        // directed: each mode, both polarities
        for (int md = 0; md < 4; md++) begin
            for (int s = 0; s < 2; s++) begin
                run_event(2'(md), 1'(s));
                drain_and_clear();
                @(negedge clk);
                check({fault_det, gate_lock, gate_force, fault_onehot} == 10'd0, "R9 clear outputs",
                      {fault_det, gate_lock, gate_force, fault_onehot}, 0);
            end
        end

        // R8 later events ignored
        run_event(2'b11, 1'b0);
        held = fault_onehot;
        gate_cmd = gates_for(2'b00);
        sm_async = 1'b1;
        sid_async = 1'b1;
        repeat (8) @(negedge clk);
        check(fault_onehot == held, "R8 verdict kept", fault_onehot, held);
        check(fault_det && gate_lock && gate_force == 4'b0000, "R8 lock kept",
              {fault_det, gate_lock, gate_force}, 6'b110000);
        gate_cmd = gates_for(2'b10);
        repeat (8) @(negedge clk);
        check(gate_force == 4'b0000, "R8 no probe after verdict", gate_force, 0);

        // R9 clear wins over a live term, then re-arms
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        check(fault_det == 1'b0, "R9 clear priority", fault_det, 0);
        @(negedge clk);
        check(fault_det == 1'b1, "R9 re-armed", fault_det, 1);
        drain_and_clear();

        // random trials
        for (int t = 0; t < 24; t++) begin
            logic [1:0] md;
            logic       smv;
            md  = 2'($urandom % 4);
            smv = 1'($urandom % 2);
            run_event(md, smv);
            check($countones(fault_onehot) == 1, "R11 single verdict bit",
                  $countones(fault_onehot), 1);
            drain_and_clear();
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule